// File: doc/BRIEF.md
# Sized ALU with condition-code register

This block is the arithmetic and logic stage of a small CPU core whose data path works at three operand widths: 8, 16 and 32 bits. Each accepted operation takes an opcode, a width code and two operands. It produces a width-limited result, a write-enable for the destination register and an updated 8-bit condition-code register. The flag update follows the operation class. Arithmetic operations produce all four arithmetic flags. Increment and decrement keep the carry flag and use their own overflow rule. Logic operations and moves clear the overflow flag and keep the carry flag. Three immediate forms apply AND, OR or XOR to the flag byte itself.

Operands come in on a valid strobe. The block has no ready signal and never exerts back-pressure: it accepts an operation on every rising edge where `in_valid` is high. Each operation shows up one cycle later on `out_valid`, `out_result`, `out_wr_en` and `out_ccr`. A cycle without `in_valid` is a bubble. Operand fetch, addressing and instruction decode are done upstream.

Flag byte layout, bit 7 down to bit 0: interrupt mask, user bit, half carry, user bit, N, Z, V, C. The ALU operations never change bits 7..4.

Top module: `flag_alu`

## Requirements
- R1: While reset is held, `out_ccr` is 0x80, `out_result` is 0, and `out_wr_en` and `out_valid` are 0.
- R2: An operation accepted at a rising edge shows up after that edge, with `out_valid` high. In a cycle where `in_valid` is low, the next edge leaves `out_ccr` and `out_result` unchanged and drives `out_valid` and `out_wr_en` to 0.
- R3: Width code 0 means 8 bits, 1 means 16 bits, and 2 or 3 means 32 bits. Operand bits above the width are ignored, and result bits above the width read 0.
- R4: Opcode 0 (add) and opcode 1 (add plus C) write the sum. C becomes the carry out of the top bit. V is set when both operands share a sign and the result's sign differs from operand A's sign.
- R5: Opcode 2 (A minus B) and opcode 3 (A minus B minus C) write the difference. C becomes the unsigned borrow. V is set when the operand signs differ and the result's sign differs from operand A's sign.
- R6: Opcode 4 (negate) writes 0 minus A. V is set exactly when A is the most negative value of the width. C is set when A is nonzero.
- R7: Opcode 5 (compare) updates N, Z, V and C exactly as opcode 2 does, but leaves `out_wr_en` low.
- R8: Opcode 6 (A plus B) and opcode 7 (A minus B) are increment and decrement. They keep C. V is set when all bits of A below its sign bit are ones.
- R9: Opcodes 8 (AND), 9 (OR), 10 (XOR), 11 (NOT of A) and 12 (move B) write their result, clear V and keep C.
- R10: Opcodes 13, 14 and 15 apply AND, OR and XOR respectively to the flag byte, using B[7:0], across all eight bits. `out_wr_en` stays low and the result reads 0.
- R11: After every opcode from 0 to 12, N equals the sign bit of the width-limited result and Z is set exactly when that result is zero. Bits 7..4 of the flag byte are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| in_op | input | 4 | Opcode, 0..15 |
| in_size | input | 2 | Width code |
| in_a | input | 32 | Operand A (destination value) |
| in_b | input | 32 | Operand B (source value or immediate) |
| out_valid | output | 1 | Result of an accepted operation |
| out_result | output | 32 | Width-limited result |
| out_wr_en | output | 1 | Destination register write-enable |
| out_ccr | output | 8 | Current condition-code byte |

## Verification
The assertions assume that `in_op` and `in_size` are meaningful only when `in_valid` is high. All 16 opcodes and 4 width codes are legal, so any value on those inputs is acceptable. The stimulus drives arbitrary operands and opcodes, including junk during bubbles. This shows that a low strobe really masks them. Directed steps exercise the sign and carry boundaries, and thousands of random operations drive the flag byte through values chosen by the flag-register operations.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD   = 4'd0,
    OP_ADDC  = 4'd1,
    OP_SUB   = 4'd2,
    OP_SUBC  = 4'd3,
    OP_NEG   = 4'd4,
    OP_CMP   = 4'd5,
    OP_INC   = 4'd6,
    OP_DEC   = 4'd7,
    OP_AND   = 4'd8,
    OP_OR    = 4'd9,
    OP_XOR   = 4'd10,
    OP_NOT   = 4'd11,
    OP_MOV   = 4'd12,
    OP_CCAND = 4'd13,
    OP_CCOR  = 4'd14,
    OP_CCXOR = 4'd15
  } alu_op_e;

  localparam int FLG_C = 0;
  localparam int FLG_V = 1;
  localparam int FLG_Z = 2;
  localparam int FLG_N = 3;

  function automatic logic op_is_arith(alu_op_e op);
    return op inside {OP_ADD, OP_ADDC, OP_SUB, OP_SUBC, OP_NEG, OP_CMP, OP_INC, OP_DEC};
  endfunction

  function automatic logic op_is_ccr(alu_op_e op);
    return op inside {OP_CCAND, OP_CCOR, OP_CCXOR};
  endfunction

endpackage

// File: rtl/sized_addsub.sv
module sized_addsub #(
  parameter int N = 8
) (
  input  logic [N-1:0] x,
  input  logic [N-1:0] y,
  input  logic         sub,
  input  logic         cin,
  output logic [N-1:0] sum,
  output logic         cout,
  output logic         ovf
);
  logic [N-1:0] y_eff;
  logic         c_eff;
  logic         carry;

  always_comb begin
    y_eff = sub ? ~y : y;
    c_eff = sub ? ~cin : cin;
    {carry, sum} = {1'b0, x} + {1'b0, y_eff} + {{N{1'b0}}, c_eff};
    cout = sub ? ~carry : carry;
    ovf  = (x[N-1] == y_eff[N-1]) && (sum[N-1] != x[N-1]);
  end
endmodule

// File: rtl/alu_arith.sv
module alu_arith
  import flag_alu_pkg::*;
#(
  parameter int W   = 32,
  parameter int NSZ = 3
) (
  input  alu_op_e      op,
  input  logic [1:0]   sz_idx,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         c_in,
  output logic [W-1:0] res,
  output logic         v,
  output logic         c
);
  logic [W-1:0] x, y;
  logic         sub, cin;
  logic [W-1:0] lane_res [NSZ];
  logic         lane_v   [NSZ];
  logic         lane_c   [NSZ];

  always_comb begin
    x   = a;
    y   = b;
    sub = 1'b0;
    cin = 1'b0;
    case (op)
      OP_ADDC:                  cin = c_in;
      OP_SUB, OP_CMP, OP_DEC:   sub = 1'b1;
      OP_SUBC: begin sub = 1'b1; cin = c_in; end
      OP_NEG:  begin x = '0; y = a; sub = 1'b1; end
      default: ;
    endcase
  end

  for (genvar g = 0; g < NSZ; g++) begin : g_lane
    localparam int LW = 8 << g;
    logic [LW-1:0] s;
    sized_addsub #(.N(LW)) u_as (
      .x(x[LW-1:0]), .y(y[LW-1:0]), .sub(sub), .cin(cin),
      .sum(s), .cout(lane_c[g]), .ovf(lane_v[g])
    );
    assign lane_res[g] = W'(s);
  end

  always_comb begin
    res = '0;
    v   = 1'b0;
    c   = 1'b0;
    for (int g = 0; g < NSZ; g++) begin
      if (sz_idx == 2'(g)) begin
        res = lane_res[g];
        v   = lane_v[g];
        c   = lane_c[g];
      end
    end
  end

  always_comb begin
    if (op == OP_NEG && a == '0)
      assert_neg_zero_R6: assert (res == '0 && !c);
  end
endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import flag_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res
);
  always_comb begin
    case (op)
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      OP_NOT:  res = ~a;
      OP_MOV:  res = b;
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import flag_alu_pkg::*;
#(
  parameter int         W         = 32,
  parameter logic [7:0] CCR_RESET = 8'h80
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [3:0]   in_op,
  input  logic [1:0]   in_size,
  input  logic [31:0]  in_a,
  input  logic [31:0]  in_b,
  output logic         out_valid,
  output logic [31:0]  out_result,
  output logic         out_wr_en,
  output logic [7:0]   out_ccr
);
  localparam int NSZ = $clog2(W / 8) + 1;

  alu_op_e      op;
  logic [1:0]   sz_idx;
  logic [W-1:0] mask, mag;
  int           sign_pos;
  logic [W-1:0] ar_res, lg_res, res_masked, res_nxt;
  logic         ar_v, ar_c, inc_v, n_f, z_f, is_write;
  logic [7:0]   ccr_q, ccr_nxt;
  logic [W-1:0] res_q;
  logic         we_q, ov_q;

  assign op     = alu_op_e'(in_op);
  assign sz_idx = (int'(in_size) >= NSZ) ? 2'(NSZ - 1) : in_size;

  always_comb begin
    mask     = '0;
    sign_pos = 7;
    for (int g = 0; g < NSZ; g++) begin
      if (sz_idx == 2'(g)) begin
        mask     = W'((64'd1 << (8 << g)) - 64'd1);
        sign_pos = (8 << g) - 1;
      end
    end
    mag = mask >> 1;
  end

  alu_arith #(.W(W), .NSZ(NSZ)) u_arith (
    .op(op), .sz_idx(sz_idx), .a(in_a), .b(in_b), .c_in(ccr_q[FLG_C]),
    .res(ar_res), .v(ar_v), .c(ar_c)
  );

  alu_logic #(.W(W)) u_logic (
    .op(op), .a(in_a), .b(in_b), .res(lg_res)
  );

  always_comb begin
    res_masked = (op_is_arith(op) ? ar_res : lg_res) & mask;
    n_f        = res_masked[sign_pos];
    z_f        = (res_masked == '0);
    inc_v      = ((in_a & mag) == mag);
    is_write   = !(op_is_ccr(op) || op == OP_CMP);
    res_nxt    = op_is_ccr(op) ? '0 : res_masked;
    ccr_nxt    = ccr_q;
    case (op)
      OP_INC, OP_DEC: ccr_nxt[3:0] = {n_f, z_f, inc_v, ccr_q[FLG_C]};
      OP_AND, OP_OR, OP_XOR, OP_NOT, OP_MOV:
                      ccr_nxt[3:0] = {n_f, z_f, 1'b0, ccr_q[FLG_C]};
      OP_CCAND:       ccr_nxt = ccr_q & in_b[7:0];
      OP_CCOR:        ccr_nxt = ccr_q | in_b[7:0];
      OP_CCXOR:       ccr_nxt = ccr_q ^ in_b[7:0];
      default:        ccr_nxt[3:0] = {n_f, z_f, ar_v, ar_c};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ccr_q <= CCR_RESET;
      res_q <= '0;
      we_q  <= 1'b0;
      ov_q  <= 1'b0;
    end else begin
      ov_q <= in_valid;
      we_q <= in_valid && is_write;
      if (in_valid) begin
        ccr_q <= ccr_nxt;
        res_q <= res_nxt;
      end
    end
  end

  assign out_valid  = ov_q;
  assign out_wr_en  = we_q;
  assign out_ccr    = ccr_q;
  assign out_result = 32'(res_q);

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_ccr) && $stable(out_result) && !out_wr_en && !out_valid);

  assert_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_size == 2'd0 |=> out_result[31:8] == 24'd0);

  assert_cmp_nowrite_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_op == OP_CMP |=> !out_wr_en);

  assert_incdec_carry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (in_op == OP_INC || in_op == OP_DEC) |=> out_ccr[0] == $past(out_ccr[0]));

  assert_logic_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_op >= OP_AND && in_op <= OP_MOV
    |=> out_ccr[0] == $past(out_ccr[0]) && !out_ccr[1]);

  assert_ccr_nowrite_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_op >= OP_CCAND |=> !out_wr_en && out_result == 32'd0);

  assert_zero_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_wr_en |-> out_ccr[2] == (out_result == 32'd0));

  assert_upper_keep_R11: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_op < OP_CCAND |=> out_ccr[7:4] == $past(out_ccr[7:4]));
endmodule

// File: tb/flag_alu_test.sv
`timescale 1ns/1ps
module flag_alu_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [3:0]  in_op = '0;
  logic [1:0]  in_size = '0;
  logic [31:0] in_a = '0, in_b = '0;
  logic        out_valid, out_wr_en;
  logic [31:0] out_result;
  logic [7:0]  out_ccr;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [7:0]  exp_cc = 8'h80;
  logic [31:0] exp_res = '0;
  logic        exp_we = 1'b0;
  logic        exp_ov = 1'b0;

  always #10 clk = ~clk;

  flag_alu uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op), .in_size(in_size),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_result(out_result),
    .out_wr_en(out_wr_en), .out_ccr(out_ccr)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic string tag(logic [3:0] op);
    case (op)
      4'd0, 4'd1:        return "R4";
      4'd2, 4'd3:        return "R5";
      4'd4:              return "R6";
      4'd5:              return "R7";
      4'd6, 4'd7:        return "R8";
      4'd13, 4'd14, 4'd15: return "R10";
      default:           return "R9";
    endcase
  endfunction

  // Behavioural reference: one operation on the expected state.
  function automatic void model(input logic [3:0] op, input logic [1:0] sz,
                                input logic [31:0] a, input logic [31:0] b,
                                inout logic [7:0] cc, output logic [31:0] res,
                                output logic we);
    int nb;
    logic [63:0] m, x, y, r, top, bi;
    logic cf, vf;
    nb  = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    m   = (64'd1 << nb) - 64'd1;
    top = 64'd1 << (nb - 1);
    x   = {32'd0, a} & m;
    y   = {32'd0, b} & m;
    cf  = cc[0];
    vf  = cc[1];
    bi  = {63'd0, cf};
    r   = '0;
    we  = 1'b1;
    case (op)
      4'd0, 4'd1: begin
        r  = x + y + ((op == 4'd1) ? bi : 64'd0);
        cf = (r & (m + 64'd1)) != 0;
        vf = ((x & top) == (y & top)) && ((r & top) != (x & top));
      end
      4'd2, 4'd3, 4'd5: begin
        if (op != 4'd3) bi = 64'd0;
        r  = x - y - bi;
        cf = x < (y + bi);
        vf = ((x & top) != (y & top)) && ((r & top) != (x & top));
        if (op == 4'd5) we = 1'b0;
      end
      4'd4: begin r = 64'd0 - x; cf = x != 0; vf = (x == top); end
      4'd6, 4'd7: begin
        r  = (op == 4'd6) ? x + y : x - y;
        vf = (x & (m >> 1)) == (m >> 1);
      end
      4'd8:  begin r = x & y; vf = 1'b0; end
      4'd9:  begin r = x | y; vf = 1'b0; end
      4'd10: begin r = x ^ y; vf = 1'b0; end
      4'd11: begin r = ~x;    vf = 1'b0; end
      4'd12: begin r = y;     vf = 1'b0; end
      default: ;
    endcase
    if (op >= 4'd13) begin
      we  = 1'b0;
      res = '0;
      if (op == 4'd13) cc = cc & b[7:0];
      else if (op == 4'd14) cc = cc | b[7:0];
      else cc = cc ^ b[7:0];
    end else begin
      r   = r & m;
      res = r[31:0];
      cc[3:0] = {(r & top) != 0, r == 0, vf, cf};
    end
  endfunction

  // Drive at a falling edge, compare at the next falling edge.
  task automatic step(logic v, logic [3:0] op, logic [1:0] sz, logic [31:0] a, logic [31:0] b);
    string t;
    in_valid = v; in_op = op; in_size = sz; in_a = a; in_b = b;
    if (v) begin
      model(op, sz, a, b, exp_cc, exp_res, exp_we);
      exp_ov = 1'b1;
      t = tag(op);
    end else begin
      exp_we = 1'b0;
      exp_ov = 1'b0;
      t = "R2";
    end
    @(negedge clk);
    check(t, "flags", 32'(out_ccr), 32'(exp_cc));
    check(t, "result", out_result, exp_res);
    check(t, "wr_en", 32'(out_wr_en), 32'(exp_we));
    check("R2", "valid", 32'(out_valid), 32'(exp_ov));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "reset flags", 32'(out_ccr), 32'h80);
    check("R1", "reset result", out_result, 32'h0);
    check("R1", "reset wr_en", 32'(out_wr_en), 32'h0);
    check("R1", "reset valid", 32'(out_valid), 32'h0);
    rst_n = 1'b1;

    step(1, 4'd0, 2'd0, 32'h0000_007f, 32'h0000_0001);         // R4 signed overflow
    check("R4", "7f+1 value", out_result, 32'h80);
    check("R4", "7f+1 flags", 32'(out_ccr), 32'h8a);
    step(1, 4'd0, 2'd0, 32'hffff_ffff, 32'h0000_0001);         // R4 carry, R3 upper ignored
    check("R3", "byte wrap", out_result, 32'h0);
    check("R4", "ff+1 flags", 32'(out_ccr), 32'h85);
    step(1, 4'd1, 2'd1, 32'h0000_ffff, 32'h0000_0000);         // R4 carry in
    check("R4", "addc flags", 32'(out_ccr), 32'h85);
    step(1, 4'd2, 2'd1, 32'h0000_0000, 32'h0000_0001);         // R5 borrow
    check("R5", "0-1 word", out_result, 32'hffff);
    check("R5", "0-1 flags", 32'(out_ccr), 32'h89);
    step(1, 4'd2, 2'd2, 32'h8000_0000, 32'h0000_0001);         // R5 overflow
    check("R5", "min-1 flags", 32'(out_ccr), 32'h82);
    step(1, 4'd4, 2'd3, 32'h8000_0000, 32'h0);                 // R6 most negative
    check("R6", "neg min flags", 32'(out_ccr), 32'h8b);
    step(1, 4'd5, 2'd0, 32'h5, 32'h5);                         // R7 compare
    check("R7", "cmp no write", 32'(out_wr_en), 32'h0);
    check("R7", "cmp flags", 32'(out_ccr), 32'h84);
    step(1, 4'd14, 2'd0, 32'h0, 32'h0000_0001);                // R10 set C
    check("R10", "orc flags", 32'(out_ccr), 32'h85);
    step(1, 4'd6, 2'd0, 32'h7f, 32'h1);                        // R8 keeps C
    check("R8", "inc flags", 32'(out_ccr), 32'h8b);
    step(1, 4'd8, 2'd1, 32'h1234_00f0, 32'h0000_000f);         // R9
    check("R9", "and flags", 32'(out_ccr), 32'h85);
    step(0, 4'd15, 2'd2, 32'hdead_beef, 32'h0000_00ff);        // R2 bubble
    check("R2", "bubble flags", 32'(out_ccr), 32'h85);
    step(1, 4'd15, 2'd0, 32'h0, 32'h0000_00ff);                // R10 xor
    check("R10", "xorc flags", 32'(out_ccr), 32'h7a);
    step(1, 4'd13, 2'd0, 32'h0, 32'h0);                        // R10 and
    step(1, 4'd7, 2'd1, 32'h0000_8000, 32'h1);                 // R8 dec
    check("R8", "dec value", out_result, 32'h7fff);
    step(1, 4'd11, 2'd2, 32'h0, 32'h0);                        // R9 not, R11 N
    check("R11", "not flags", 32'(out_ccr), 32'h08);

    for (int i = 0; i < 4000; i++) begin
      logic [31:0] ra, rb;
      ra = $urandom();
      rb = $urandom();
      if (($urandom() & 3) == 0) ra = {$urandom_range(0, 1) != 0, 31'd0} | (ra & 32'h0000_00ff);
      step(($urandom() & 7) != 0, 4'($urandom()), 2'($urandom()), ra, rb);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule